// File: doc/BRIEF.md
# Buck Converter Fault Supervisor with Hiccup Restart

This block is the fault state machine of a synchronous buck regulator. It advances once per switching cycle, on a cycle strobe. Its inputs are the digital outcomes of the analog comparators: overcurrent on the high-side switch, undervoltage, overvoltage and over-temperature. From these it decides whether the regulator runs, clamps its output through the low-side switch, tri-states the drivers, or restarts through a hiccup sequence.

A fault that lasts for a set number of consecutive cycles leads into hiccup. In hiccup the soft-start capacitor is discharged and the soft-start ramp then runs three times with the drivers off, to let the switches cool. A fourth ramp restarts the regulator for real. Overvoltage escalates in steps. It first forces the low-side switch on. If it persists, the drivers are tri-stated, and the collapsing output then reaches hiccup through the undervoltage path. The soft-start ramp, the PWM generator and the analog sensing lie outside the block, which issues requests to them.

Top module: `buck_fault_supervisor`

## Requirements
- R1: While `en` is low, the state becomes OFF (code 0) at the next clock edge, with or without a strobe. Every consecutive-fault counter and the hiccup progress are cleared. After `rst` the state is OFF.
- R2: From OFF, or from the thermal state once cleared, the first strobe enters the discharge phase (code 4). After `DIS_CYCLES` strobes (default 2) the state goes straight to RUN (code 1), with no dummy ramps.
- R3: In RUN, `pulse_term` follows `oc_flag` in the same cycle, with no clock delay.
- R4: In RUN with `ss_done` high, `OC_LIMIT` (default 8) consecutive strobes with `oc_flag` high enter the discharge phase (code 4). A strobe without overcurrent restarts the count.
- R5: While `ss_done` is low in RUN, the overcurrent count is held at zero, although pulse termination still works.
- R6: A hiccup entered from a fault discharges for `DIS_CYCLES` strobes and then waits in code 5 until a strobe sees `ss_done` high. It then discharges again. After the third such dummy ramp, the discharge phase leads to RUN.
- R7: In RUN with `ss_done` high, `UV_LIMIT` (default 8) consecutive strobes with `uv_flag` high enter the discharge phase. While `ss_done` is low, the undervoltage count is held at zero.
- R8: A strobe in RUN with `ov_flag` high enters the clamp state (code 2), which asserts `force_lo` and `pulse_term`. A strobe in the clamp state with `ov_flag` low returns to RUN.
- R9: `OV_LIMIT` (default 32) consecutive overvoltage strobes, counting the one that entered the clamp, enter the shut state (code 3) with the drivers tri-stated. There, `UV_LIMIT` consecutive undervoltage strobes enter the discharge phase, whatever the level of `ss_done`.
- R10: With `en` high, `therm_flag` high moves the state to code 6 at the next clock edge, with the drivers tri-stated. The state stays there until a strobe sees `therm_flag` low.
- R11: With `en` high and `therm_flag` low, the state changes only on clock edges where `cyc_stb` is high.
- R12: The outputs decode the state as follows. `drv_tristate` is high in codes 0, 3, 4, 5 and 6. `ss_discharge` is high in codes 0, 4 and 6. `force_lo` is high only in code 2. `pulse_term` is high in code 2, and in code 1 when `oc_flag` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One pulse per switching cycle |
| en | input | 1 | Regulator enable |
| ss_done | input | 1 | Soft-start ramp has completed |
| oc_flag | input | 1 | Overcurrent seen while the high-side switch is on |
| uv_flag | input | 1 | Feedback below the undervoltage threshold |
| ov_flag | input | 1 | Feedback above the overvoltage threshold |
| therm_flag | input | 1 | Over-temperature |
| pulse_term | output | 1 | Terminate the present high-side pulse |
| force_lo | output | 1 | Hold the low-side switch on |
| drv_tristate | output | 1 | Tri-state both gate drivers |
| ss_discharge | output | 1 | Discharge the soft-start capacitor and hold it discharged |
| state | output | 3 | State code: 0 off, 1 run, 2 clamp, 3 shut, 4 discharge, 5 dummy ramp, 6 thermal |

## Verification
The overcurrent counter is tried with an unbroken run of eight faulty strobes and with a run of seven, one clean strobe and seven more. Telling these apart shows that the count is consecutive rather than cumulative. The count is also driven with faults during soft-start and with faults held between strobes, which separates the soft-start hold and the strobe gating from plain counting. Overvoltage is driven for 31 and then 32 strobes to pin the escalation boundary, and is then followed by an undervoltage run. Enable and thermal events are injected mid-count and mid-hiccup to show that counters and dummy-ramp progress restart from zero.

// File: rtl/fsup_pkg.sv
package fsup_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_RUN     = 3'd1,
        ST_OVCLAMP = 3'd2,
        ST_OVOFF   = 3'd3,
        ST_HDIS    = 3'd4,
        ST_HWAIT   = 3'd5,
        ST_THERM   = 3'd6
    } fsup_state_e;

    typedef struct packed {
        logic pulse_term;
        logic force_lo;
        logic drv_tri;
        logic ss_dis;
    } drive_req_t;

    function automatic int safe_clog2(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic drivers_off(input fsup_state_e s);
        return (s == ST_OFF) || (s == ST_OVOFF) || (s == ST_HDIS) ||
               (s == ST_HWAIT) || (s == ST_THERM);
    endfunction

    function automatic logic discharging(input fsup_state_e s);
        return (s == ST_OFF) || (s == ST_HDIS) || (s == ST_THERM);
    endfunction

endpackage

// File: rtl/fsup_consec_cnt.sv
module fsup_consec_cnt #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stb,
    input  logic hit,
    input  logic hold,
    output logic reach
);
    import fsup_pkg::*;

    localparam int W = safe_clog2(LIMIT);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign reach = stb & hit & ~hold & (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (stb) begin
            if (hold || !hit || reach) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fsup_fsm.sv
module fsup_fsm #(
    parameter int DUMMY_RUNS = 3,
    parameter int DIS_CYCLES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  en,
    input  logic                  therm,
    input  logic                  stb,
    input  logic                  ss_done,
    input  logic                  ov,
    input  logic                  oc_reach,
    input  logic                  uv_reach,
    input  logic                  ov_reach,
    output fsup_pkg::fsup_state_e st
);
    import fsup_pkg::*;

    localparam int DW = safe_clog2(DIS_CYCLES);
    localparam int UW = safe_clog2(DUMMY_RUNS + 1);
    localparam logic [DW-1:0] DIS_LAST  = DW'(DIS_CYCLES - 1);
    localparam logic [UW-1:0] DUMMY_ALL = UW'(DUMMY_RUNS);

    fsup_state_e     nxt;
    logic [DW-1:0]   dis_cnt;
    logic [UW-1:0]   dummy;

    always_comb begin
        nxt = st;
        unique case (st)
            ST_OFF:     if (stb) nxt = ST_HDIS;
            ST_HDIS:    if (stb && dis_cnt == DIS_LAST)
                            nxt = (dummy == DUMMY_ALL) ? ST_RUN : ST_HWAIT;
            ST_HWAIT:   if (stb && ss_done) nxt = ST_HDIS;
            ST_RUN:     if (stb) begin
                            if (ov) nxt = ST_OVCLAMP;
                            else if (oc_reach || uv_reach) nxt = ST_HDIS;
                        end
            ST_OVCLAMP: if (stb) begin
                            if (!ov) nxt = ST_RUN;
                            else if (ov_reach) nxt = ST_OVOFF;
                        end
            ST_OVOFF:   if (uv_reach) nxt = ST_HDIS;
            ST_THERM:   if (stb && !therm) nxt = ST_HDIS;
            default:    nxt = ST_OFF;
        endcase
        if (therm) nxt = ST_THERM;
        if (!en)   nxt = ST_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_OFF;
        end else begin
            st <= nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dis_cnt <= '0;
        end else if (st == ST_HDIS && nxt == ST_HDIS) begin
            if (stb) dis_cnt <= dis_cnt + 1'b1;
        end else begin
            dis_cnt <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            dummy <= DUMMY_ALL;
        end else if (nxt == ST_HDIS && st != ST_HDIS) begin
            if (st == ST_HWAIT) begin
                dummy <= dummy + 1'b1;
            end else if (st == ST_RUN || st == ST_OVOFF) begin
                dummy <= '0;
            end else begin
                dummy <= DUMMY_ALL;
            end
        end
    end

endmodule

// File: rtl/fsup_drive_decode.sv
module fsup_drive_decode (
    input  fsup_pkg::fsup_state_e st,
    input  logic                  oc,
    output fsup_pkg::drive_req_t  req
);
    import fsup_pkg::*;

    always_comb begin
        req.force_lo   = (st == ST_OVCLAMP);
        req.pulse_term = (st == ST_OVCLAMP) || ((st == ST_RUN) && oc);
        req.drv_tri    = drivers_off(st);
        req.ss_dis     = discharging(st);
    end

endmodule

// File: rtl/buck_fault_supervisor.sv
module buck_fault_supervisor #(
    parameter int OC_LIMIT   = 8,
    parameter int UV_LIMIT   = 8,
    parameter int OV_LIMIT   = 32,
    parameter int DUMMY_RUNS = 3,
    parameter int DIS_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cyc_stb,
    input  logic       en,
    input  logic       ss_done,
    input  logic       oc_flag,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       therm_flag,
    output logic       pulse_term,
    output logic       force_lo,
    output logic       drv_tristate,
    output logic       ss_discharge,
    output logic [2:0] state
);
    import fsup_pkg::*;

    fsup_state_e st;
    drive_req_t  req;
    logic        oc_reach, uv_reach, ov_reach;
    logic        abort;

    assign abort = !en || therm_flag;

    fsup_consec_cnt #(.LIMIT(OC_LIMIT)) u_oc_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort || st != ST_RUN),
        .stb   (cyc_stb),
        .hit   (oc_flag),
        .hold  (!ss_done),
        .reach (oc_reach)
    );

    fsup_consec_cnt #(.LIMIT(UV_LIMIT)) u_uv_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort || !(st == ST_RUN || st == ST_OVOFF)),
        .stb   (cyc_stb),
        .hit   (uv_flag),
        .hold  (st == ST_RUN && !ss_done),
        .reach (uv_reach)
    );

    fsup_consec_cnt #(.LIMIT(OV_LIMIT)) u_ov_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr   (abort || !(st == ST_RUN || st == ST_OVCLAMP)),
        .stb   (cyc_stb),
        .hit   (ov_flag),
        .hold  (1'b0),
        .reach (ov_reach)
    );

    fsup_fsm #(
        .DUMMY_RUNS (DUMMY_RUNS),
        .DIS_CYCLES (DIS_CYCLES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .therm    (therm_flag),
        .stb      (cyc_stb),
        .ss_done  (ss_done),
        .ov       (ov_flag),
        .oc_reach (oc_reach && st == ST_RUN),
        .uv_reach (uv_reach && (st == ST_RUN || st == ST_OVOFF)),
        .ov_reach (ov_reach && st == ST_OVCLAMP),
        .st       (st)
    );

    fsup_drive_decode u_dec (
        .st  (st),
        .oc  (oc_flag),
        .req (req)
    );

    assign pulse_term   = req.pulse_term;
    assign force_lo     = req.force_lo;
    assign drv_tristate = req.drv_tri;
    assign ss_discharge = req.ss_dis;
    assign state        = st;

endmodule

// File: rtl/fsup_checker.sv
module fsup_checker (
    input logic       clk,
    input logic       rst,
    input logic       cyc_stb,
    input logic       en,
    input logic       ss_done,
    input logic       oc_flag,
    input logic       uv_flag,
    input logic       ov_flag,
    input logic       therm_flag,
    input logic       pulse_term,
    input logic       force_lo,
    input logic       drv_tristate,
    input logic       ss_discharge,
    input logic [2:0] state
);

    // R1
    en_off_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == 3'd0);

    // R10
    therm_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (en && therm_flag) |=> state == 3'd6);

    // R11
    strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !therm_flag && !cyc_stb) |=> $stable(state));

    // R8
    clamp_excl_chk: assert property (@(posedge clk) disable iff (rst)
        force_lo |-> (!drv_tristate && pulse_term));

    // R9
    ovoff_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd3) |-> ($past(state) == 3'd2 || $past(state) == 3'd3));

    // R6
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (state == 3'd1 && $past(state) != 3'd1) |->
        ($past(state) == 3'd4 || $past(state) == 3'd2));

    // R12
    tri_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        drv_tristate |-> !pulse_term);

endmodule

bind buck_fault_supervisor fsup_checker u_chk (.*);

// File: tb/buck_fault_supervisor_bench.sv
module buck_fault_supervisor_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 25;

    logic clk = 1'b0;
    logic rst, cyc_stb, en, ss_done, oc_flag, uv_flag, ov_flag, therm_flag;
    logic pulse_term, force_lo, drv_tristate, ss_discharge;
    logic [2:0] state;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    buck_fault_supervisor u_buck_fault_supervisor (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .en(en), .ss_done(ss_done),
        .oc_flag(oc_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .therm_flag(therm_flag), .pulse_term(pulse_term), .force_lo(force_lo),
        .drv_tristate(drv_tristate), .ss_discharge(ss_discharge), .state(state)
    );

    // {stb, ss_done, oc, uv, ov, expected state[2:0]}
    localparam logic [7:0] VEC [NVEC] = '{
        8'b1_0_0_0_0_100, 8'b1_0_0_0_0_100, 8'b1_0_0_0_0_001,
        8'b1_0_1_0_0_001, 8'b1_1_0_0_0_001,
        8'b1_1_1_0_0_001, 8'b1_1_1_0_0_001, 8'b1_1_1_0_0_001,
        8'b1_1_1_0_0_001, 8'b1_1_1_0_0_001, 8'b1_1_1_0_0_001,
        8'b1_1_1_0_0_001, 8'b1_1_1_0_0_100,
        8'b1_0_0_0_0_100, 8'b1_0_0_0_0_101, 8'b1_0_0_0_0_101,
        8'b1_1_0_0_0_100, 8'b1_0_0_0_0_100, 8'b1_0_0_0_0_101,
        8'b1_1_0_0_0_100, 8'b1_0_0_0_0_100, 8'b1_0_0_0_0_101,
        8'b1_1_0_0_0_100, 8'b1_0_0_0_0_100, 8'b1_0_0_0_0_001
    };

    // Expected {pulse_term, force_lo, drv_tristate, ss_discharge} per R12
    function automatic logic [3:0] exp_out(input logic [2:0] s, input logic oc);
        logic pt, fl, tr, sd;
        pt = (s == 3'd2) || (s == 3'd1 && oc);
        fl = (s == 3'd2);
        tr = (s == 3'd0) || (s == 3'd3) || (s == 3'd4) || (s == 3'd5) || (s == 3'd6);
        sd = (s == 3'd0) || (s == 3'd4) || (s == 3'd6);
        return {pt, fl, tr, sd};
    endfunction

    task automatic chk(input string req, input logic [2:0] exp_st);
        logic [3:0] e, a;
        e = exp_out(exp_st, oc_flag);
        a = {pulse_term, force_lo, drv_tristate, ss_discharge};
        checks++;
        if (state !== exp_st || a !== e) begin
            errors++;
            $display("FAIL %s: state=%0d outs=%b expected state=%0d outs=%b",
                     req, state, a, exp_st, e);
        end
    endtask

    task automatic tick(input logic s);
        cyc_stb = s;
        @(posedge clk);
        #1;
        cyc_stb = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick(1'b1);
    endtask

    task automatic go_run();
        en = 1'b0; oc_flag = 0; uv_flag = 0; ov_flag = 0; therm_flag = 0; ss_done = 0;
        tick(1'b0);
        en = 1'b1;
        ticks(3);
        chk("R2 restart reaches run", 3'd1);
        ss_done = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1; cyc_stb = 0; en = 1; ss_done = 0;
        oc_flag = 0; uv_flag = 0; ov_flag = 0; therm_flag = 0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R1 reset state off", 3'd0);
        rst = 0;

        // R6 R4 R5 R3 R2: start, soft-start hold, 8-cycle trip, three dummy ramps
        for (int i = 0; i < NVEC; i++) begin
            ss_done = VEC[i][6]; oc_flag = VEC[i][5];
            uv_flag = VEC[i][4]; ov_flag = VEC[i][3];
            tick(VEC[i][7]);
            chk($sformatf("R6 vector %0d", i), VEC[i][2:0]);
        end
        oc_flag = 0; ss_done = 1;

        // R11 and R3: faults held without strobes do not count
        go_run();
        oc_flag = 1;
        for (int i = 0; i < 10; i++) tick(1'b0);
        chk("R3 pulse_term follows oc without strobe", 3'd1);
        chk("R11 no strobe keeps run", 3'd1);
        ticks(7);
        chk("R11 seven counted strobes stay run", 3'd1);
        ticks(1);
        chk("R4 eighth strobe enters hiccup", 3'd4);

        // R4: a clean cycle restarts the count
        go_run();
        oc_flag = 1; ticks(7);
        oc_flag = 0; ticks(1);
        oc_flag = 1; ticks(7);
        chk("R4 broken run stays in run", 3'd1);
        ticks(1);
        chk("R4 trip after restarted count", 3'd4);
        oc_flag = 0;

        // R7: undervoltage held during soft-start, then counted
        go_run();
        ss_done = 0; uv_flag = 1; ticks(8);
        chk("R7 uv ignored during soft-start", 3'd1);
        ss_done = 1; ticks(7);
        chk("R7 seven uv strobes stay run", 3'd1);
        ticks(1);
        chk("R7 eighth uv strobe enters hiccup", 3'd4);
        uv_flag = 0;

        // R8 R9: clamp, release, escalation, undervoltage exit
        go_run();
        ov_flag = 1; ticks(1);
        chk("R8 ov enters clamp", 3'd2);
        ov_flag = 0; ticks(1);
        chk("R8 ov gone returns to run", 3'd1);
        ov_flag = 1; ticks(1);
        ticks(30);
        chk("R9 31 ov strobes still clamp", 3'd2);
        ticks(1);
        chk("R9 32nd ov strobe shuts drivers", 3'd3);
        ov_flag = 0; uv_flag = 1; ss_done = 0; ticks(7);
        chk("R9 seven uv strobes stay shut", 3'd3);
        ticks(1);
        chk("R9 eighth uv strobe enters hiccup", 3'd4);
        uv_flag = 0; ss_done = 1;

        // R1: enable low clears counters and hiccup progress
        go_run();
        oc_flag = 1; ticks(7);
        en = 0; tick(1'b0);
        chk("R1 enable low forces off without strobe", 3'd0);
        go_run();
        oc_flag = 1; ticks(7);
        chk("R1 counter cleared by enable low", 3'd1);
        ticks(1);
        chk("R1 trip after fresh count", 3'd4);
        oc_flag = 0; ss_done = 0; ticks(2);
        chk("R6 dummy ramp wait", 3'd5);
        en = 0; tick(1'b1);
        chk("R1 off from hiccup", 3'd0);
        en = 1; ticks(3);
        chk("R1 hiccup progress cleared, direct run", 3'd1);
        ss_done = 1;

        // R10: thermal shutdown and resume
        therm_flag = 1; tick(1'b0);
        chk("R10 thermal entry without strobe", 3'd6);
        ticks(3);
        chk("R10 stays while flag high", 3'd6);
        therm_flag = 0; tick(1'b0);
        chk("R10 needs strobe to leave", 3'd6);
        ticks(1);
        chk("R10 resume discharge", 3'd4);
        ticks(2);
        chk("R10 resume reaches run", 3'd1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule